// File: doc/BRIEF.md
# PC Card Access Sequencer with Wait Extension

This block runs one access at a time to a 16-bit PC Card or CompactFlash device. The host selects one of three spaces: common memory, attribute memory or I/O. The block drives the two chip enables, the register-select line, the memory read and write strobes and the I/O read and write strobes. Each access has a one-cycle setup, an access phase with a strobe low, a one-cycle hold and a one-cycle acknowledge. Each space has its own programmed access-phase length.

When wait handling is enabled, the card can stretch the access phase by pulling its wait line low. The wait input passes through a two-flop synchronizer. It is only looked at during an early part of the access phase. Once it is released, the strobe stays low for a fixed tail of four cycles.

The block refuses byte accesses to I/O space and the reserved space code. For these it answers at once with an error and drives no strobe. The host side is a request/acknowledge pair: the host pulses `req_valid` while `req_ready` is high and waits for `rsp_ack`.

Top module: `pccard_seq`

## Requirements
- R1: While reset is held, and whenever the block is idle, both chip enables, register select and all four strobes are high, `rsp_ack` is low and `req_ready` is high.
- R2: An accepted request gives one setup cycle with the chip enables active and all strobes high. Then the strobe is low for the access phase, then one hold cycle with the chip enables still active and the strobe high, then a single `rsp_ack` cycle with the chip enables high. After that the block is ready again.
- R3: The access-phase length comes from `cfg_common_len`, `cfg_attr_len` or `cfg_io_len`, chosen by `req_space` (0 common, 1 attribute, 2 I/O). Register select is high for common memory and low for the other two. Memory spaces use `card_oe_n`/`card_we_n`. I/O uses `card_iord_n`/`card_iowr_n`.
- R4: A word access drives both chip enables low and address bit 0 low. A byte access to a memory space drives `card_ce1_n` low, `card_ce2_n` high and address bit 0 equal to `req_addr[0]`, with the data on the low lane.
- R5: A byte access to I/O space, or space code 3, is refused. No chip enable or strobe goes low, and in the cycle after acceptance `rsp_ack` and `rsp_err` are both high for one cycle.
- R6: With `cfg_wait_en` low, `card_wait_n` has no effect. The strobe is low for exactly the programmed length.
- R7: With `cfg_wait_en` high, a synchronized low wait sample seen early enough in the access phase holds the strobe low. This lasts until the first synchronized high sample, and the strobe then stays low for exactly four more cycles.
- R8: A synchronized low sample is acted on only while the access-phase cycle index (from 0) is less than the programmed length minus 4. A later low sample leaves the length unchanged.
- R9: With `cfg_wait_en` high, a programmed length below 5 acts as 5. With it low, a length of 0 acts as 1.
- R10: `rsp_rdata` holds `card_din` as sampled in the last strobe-low cycle. A byte read returns the low byte in bits 7:0 with zeros above.
- R11: For writes, `card_dout_en` is high from setup through hold and low otherwise. `card_dout` carries the write data, or for a byte write the low byte with zeros above.
- R12: A request raised while `req_ready` is low is ignored, and the access in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready |
| req_space | input | 2 | 0 common, 1 attribute, 2 I/O, 3 reserved |
| req_write | input | 1 | 1 write, 0 read |
| req_byte | input | 1 | 1 byte access, 0 word access |
| req_addr | input | AW | Card address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Block idle, request may be issued |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Refused request, with ack |
| rsp_rdata | output | DW | Captured read data |
| cfg_common_len | input | LW | Access-phase length, common memory |
| cfg_attr_len | input | LW | Access-phase length, attribute memory |
| cfg_io_len | input | LW | Access-phase length, I/O |
| cfg_wait_en | input | 1 | Enable wait stretching |
| card_ce1_n | output | 1 | Chip enable, low lane |
| card_ce2_n | output | 1 | Chip enable, high lane |
| card_reg_n | output | 1 | Register/attribute select |
| card_oe_n | output | 1 | Memory read strobe |
| card_we_n | output | 1 | Memory write strobe |
| card_iord_n | output | 1 | I/O read strobe |
| card_iowr_n | output | 1 | I/O write strobe |
| card_addr | output | AW | Address to card |
| card_dout | output | DW | Write data to card |
| card_dout_en | output | 1 | Data bus drive enable |
| card_din | input | DW | Read data from card |
| card_wait_n | input | 1 | Card wait request, active low |

## Verification
The hardest case to reach is the edge of the wait-detection window. The two synchronizer flops shift every wait edge by two cycles, so it takes exact timing to place a low sample on the last cycle where it counts, and then one cycle later. The bench drives `card_wait_n` at a chosen access-phase cycle and works out the resulting strobe length from the synchronizer delay and the window rule. It runs the pair of cases that straddle the window edge. The bench also changes `card_din` just before and just after the last strobe-low cycle, which shows the capture cycle at the ports.

// File: rtl/pccard_pkg.sv
package pccard_pkg;

  typedef enum logic [1:0] {
    SP_COMMON = 2'd0,
    SP_ATTR   = 2'd1,
    SP_IO     = 2'd2,
    SP_RSVD   = 2'd3
  } space_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_STRETCH,
    ST_TAIL,
    ST_HOLD,
    ST_ACK,
    ST_REFUSE
  } state_e;

  localparam int unsigned TAIL_CYCLES   = 4;
  localparam int unsigned MIN_WAIT_LEN  = 5;
  localparam int unsigned SYNC_STAGES   = 2;

endpackage

// File: rtl/pccard_rst_sync.sv
module pccard_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pccard_wait_sync.sv
module pccard_wait_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] sh_q;

  // Idle level of the wait line is high, so the chain resets to ones.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '1;
    end else begin
      sh_q <= {sh_q[STAGES-2:0], async_i};
    end
  end

  assign sync_o = sh_q[STAGES-1];

endmodule

// File: rtl/pccard_decode.sv
module pccard_decode
  import pccard_pkg::*;
(
  input  logic [1:0] space_i,
  input  logic       byte_i,
  input  logic       addr0_i,
  output logic       ce2_n_o,
  output logic       reg_n_o,
  output logic       a0_o,
  output logic       io_o,
  output logic       refuse_o
);

  always_comb begin
    io_o     = (space_i == 2'(SP_IO));
    reg_n_o  = (space_i == 2'(SP_COMMON));
    // Byte lanes: word uses both enables, byte uses only the low enable.
    ce2_n_o  = byte_i;
    a0_o     = byte_i & addr0_i;
    refuse_o = (space_i == 2'(SP_RSVD)) | (io_o & byte_i);
  end

endmodule

// File: rtl/pccard_seq.sv
module pccard_seq
  import pccard_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 16,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_space,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_ack,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  input  logic [LW-1:0] cfg_common_len,
  input  logic [LW-1:0] cfg_attr_len,
  input  logic [LW-1:0] cfg_io_len,
  input  logic          cfg_wait_en,
  output logic          card_ce1_n,
  output logic          card_ce2_n,
  output logic          card_reg_n,
  output logic          card_oe_n,
  output logic          card_we_n,
  output logic          card_iord_n,
  output logic          card_iowr_n,
  output logic [AW-1:0] card_addr,
  output logic [DW-1:0] card_dout,
  output logic          card_dout_en,
  input  logic [DW-1:0] card_din,
  input  logic          card_wait_n
);

  localparam int unsigned HALF = DW / 2;
  localparam int unsigned TW   = $clog2(TAIL_CYCLES);
  localparam int unsigned LX   = LW + 1;

  // ---------------------------------------------------------------- reset/sync
  logic rst_core_n;
  logic wait_s;

  pccard_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pccard_wait_sync #(.STAGES(SYNC_STAGES)) u_wait_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .async_i (card_wait_n),
    .sync_o  (wait_s)
  );

  // ---------------------------------------------------------------- request decode
  logic dec_ce2_n, dec_reg_n, dec_a0, dec_io, dec_refuse;

  pccard_decode u_decode (
    .space_i  (req_space),
    .byte_i   (req_byte),
    .addr0_i  (req_addr[0]),
    .ce2_n_o  (dec_ce2_n),
    .reg_n_o  (dec_reg_n),
    .a0_o     (dec_a0),
    .io_o     (dec_io),
    .refuse_o (dec_refuse)
  );

  // ---------------------------------------------------------------- state
  state_e          state_q, state_d;
  logic [LW-1:0]   cnt_q, cnt_d;
  logic [TW-1:0]   tail_q, tail_d;
  logic [LW-1:0]   len_q;
  logic            wen_q, write_q, byte_q, io_q, ce2_n_q, reg_n_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q, rdata_q;

  logic            accept, load_en, cap_en;
  logic [LW-1:0]   raw_len, eff_len;
  logic            in_window, last_access, wait_hit;
  logic [DW-1:0]   rdata_d;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready & req_valid;
  assign load_en   = accept & ~dec_refuse;

  // Length of the access phase for the requested space, with floors applied.
  always_comb begin
    unique case (req_space)
      2'(SP_ATTR): raw_len = cfg_attr_len;
      2'(SP_IO):   raw_len = cfg_io_len;
      default:     raw_len = cfg_common_len;
    endcase
    if (cfg_wait_en) begin
      eff_len = (raw_len < LW'(MIN_WAIT_LEN)) ? LW'(MIN_WAIT_LEN) : raw_len;
    end else begin
      eff_len = (raw_len == '0) ? LW'(1) : raw_len;
    end
  end

  assign in_window   = ({1'b0, cnt_q} + LX'(TAIL_CYCLES)) < {1'b0, len_q};
  assign last_access = (cnt_q == (len_q - LW'(1)));
  assign wait_hit    = wen_q & ~wait_s & in_window;
  assign rdata_d     = byte_q ? {{(DW-HALF){1'b0}}, card_din[HALF-1:0]} : card_din;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tail_d  = tail_q;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = dec_refuse ? ST_REFUSE : ST_SETUP;
        end
      end
      ST_SETUP: begin
        state_d = ST_ACCESS;
        cnt_d   = '0;
      end
      ST_ACCESS: begin
        if (wait_hit) begin
          state_d = ST_STRETCH;
        end else if (last_access) begin
          state_d = ST_HOLD;
          cap_en  = 1'b1;
        end else begin
          cnt_d = cnt_q + LW'(1);
        end
      end
      ST_STRETCH: begin
        if (wait_s) begin
          state_d = ST_TAIL;
          tail_d  = '0;
        end
      end
      ST_TAIL: begin
        if (tail_q == TW'(TAIL_CYCLES - 1)) begin
          state_d = ST_HOLD;
          cap_en  = 1'b1;
        end else begin
          tail_d = tail_q + TW'(1);
        end
      end
      ST_HOLD:   state_d = ST_ACK;
      ST_ACK:    state_d = ST_IDLE;
      ST_REFUSE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tail_q  <= tail_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      len_q   <= LW'(1);
      wen_q   <= 1'b0;
      write_q <= 1'b0;
      byte_q  <= 1'b0;
      io_q    <= 1'b0;
      ce2_n_q <= 1'b1;
      reg_n_q <= 1'b1;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      len_q   <= eff_len;
      wen_q   <= cfg_wait_en;
      write_q <= req_write;
      byte_q  <= req_byte;
      io_q    <= dec_io;
      ce2_n_q <= dec_ce2_n;
      reg_n_q <= dec_reg_n;
      addr_q  <= {req_addr[AW-1:1], dec_a0};
      wdata_q <= req_byte ? {{(DW-HALF){1'b0}}, req_wdata[HALF-1:0]} : req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= rdata_d;
    end
  end

  // ---------------------------------------------------------------- outputs
  logic ce_act, strobe_act;

  assign ce_act     = (state_q == ST_SETUP) | (state_q == ST_ACCESS) |
                      (state_q == ST_STRETCH) | (state_q == ST_TAIL) |
                      (state_q == ST_HOLD);
  assign strobe_act = (state_q == ST_ACCESS) | (state_q == ST_STRETCH) |
                      (state_q == ST_TAIL);

  assign card_ce1_n   = ~ce_act;
  assign card_ce2_n   = ce_act ? ce2_n_q : 1'b1;
  assign card_reg_n   = ce_act ? reg_n_q : 1'b1;
  assign card_oe_n    = ~(strobe_act & ~io_q & ~write_q);
  assign card_we_n    = ~(strobe_act & ~io_q &  write_q);
  assign card_iord_n  = ~(strobe_act &  io_q & ~write_q);
  assign card_iowr_n  = ~(strobe_act &  io_q &  write_q);
  assign card_addr    = addr_q;
  assign card_dout    = wdata_q;
  assign card_dout_en = ce_act & write_q;

  assign rsp_ack   = (state_q == ST_ACK) | (state_q == ST_REFUSE);
  assign rsp_err   = (state_q == ST_REFUSE);
  assign rsp_rdata = rdata_q;

endmodule

// File: rtl/pccard_seq_chk.sv
module pccard_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_ack,
  input logic rsp_err,
  input logic card_ce1_n,
  input logic card_ce2_n,
  input logic card_reg_n,
  input logic card_oe_n,
  input logic card_we_n,
  input logic card_iord_n,
  input logic card_iowr_n,
  input logic card_dout_en
);

  logic any_lo;
  assign any_lo = ~(card_oe_n & card_we_n & card_iord_n & card_iowr_n);

  // R1: idle means quiet card bus
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (card_ce1_n && card_ce2_n && card_reg_n && !any_lo && !rsp_ack));

  // R2: one setup cycle with enables active precedes the strobe
  assert_setup_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_lo) |-> $past(!card_ce1_n));

  // R2: hold cycle after the strobe, enables still active and no ack yet
  assert_hold_after_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_lo) |-> (!card_ce1_n && !rsp_ack));

  // R2: acknowledge lasts a single cycle
  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> !rsp_ack);

  // R3: at most one strobe active
  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!card_oe_n, !card_we_n, !card_iord_n, !card_iowr_n}) <= 1);

  // R3: I/O strobes run with register select low
  assert_io_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_iord_n || !card_iowr_n) |-> !card_reg_n);

  // R4: no strobe without the low chip enable
  assert_strobe_ce_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_lo |-> !card_ce1_n);

  // R5: error only with ack and a quiet card bus
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_ack && card_ce1_n && card_ce2_n && !any_lo));

  // R11: data drive only inside the enabled window
  assert_dout_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
    card_dout_en |-> !card_ce1_n);

  // R12: block returns to ready right after ack
  assert_ready_after_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ack |=> req_ready);

endmodule

bind pccard_seq pccard_seq_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_ack      (rsp_ack),
  .rsp_err      (rsp_err),
  .card_ce1_n   (card_ce1_n),
  .card_ce2_n   (card_ce2_n),
  .card_reg_n   (card_reg_n),
  .card_oe_n    (card_oe_n),
  .card_we_n    (card_we_n),
  .card_iord_n  (card_iord_n),
  .card_iowr_n  (card_iowr_n),
  .card_dout_en (card_dout_en)
);

// File: tb/test_pccard_seq.sv
`timescale 1ns/1ps
module test_pccard_seq;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_space = 2'd0;
  logic          req_write = 1'b0;
  logic          req_byte = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_ack, rsp_err;
  logic [DW-1:0] rsp_rdata;
  logic [LW-1:0] cfg_common_len = 8'd6;
  logic [LW-1:0] cfg_attr_len = 8'd9;
  logic [LW-1:0] cfg_io_len = 8'd7;
  logic          cfg_wait_en = 1'b0;
  logic          card_ce1_n, card_ce2_n, card_reg_n;
  logic          card_oe_n, card_we_n, card_iord_n, card_iowr_n;
  logic [AW-1:0] card_addr;
  logic [DW-1:0] card_dout;
  logic          card_dout_en;
  logic [DW-1:0] card_din = 16'hDEAD;
  logic          card_wait_n = 1'b1;

  int nvec = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pccard_seq #(.AW(AW), .DW(DW), .LW(LW)) i_pccard_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_space(req_space), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_ack(rsp_ack), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_common_len(cfg_common_len), .cfg_attr_len(cfg_attr_len), .cfg_io_len(cfg_io_len),
    .cfg_wait_en(cfg_wait_en),
    .card_ce1_n(card_ce1_n), .card_ce2_n(card_ce2_n), .card_reg_n(card_reg_n),
    .card_oe_n(card_oe_n), .card_we_n(card_we_n), .card_iord_n(card_iord_n),
    .card_iowr_n(card_iowr_n), .card_addr(card_addr), .card_dout(card_dout),
    .card_dout_en(card_dout_en), .card_din(card_din), .card_wait_n(card_wait_n)
  );

  function automatic logic [10:0] pins();
    return {card_ce1_n, card_ce2_n, card_reg_n, card_oe_n, card_we_n, card_iord_n,
            card_iowr_n, rsp_ack, rsp_err, req_ready, card_dout_en};
  endfunction

  localparam logic [10:0] IDLE_V = 11'b111_1111_0010;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One access: sp space, wr write, by byte, j = access cycle where wait_n is
  // pulled low (-1 none), r = access cycle where it is released.
  task automatic run_txn(input string tag, input logic [1:0] sp, input logic wr,
                         input logic by, input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                         input logic [DW-1:0] rd, input logic wen, input int lraw,
                         input int j, input int r, input bit poke);
    logic [10:0] q[$];
    bit refuse;
    bit io;
    int L, S, n;
    logic ce2e, rege, a0e;
    logic [DW-1:0] exp_rd, exp_wd;
    refuse = (sp == 2'd3) || (sp == 2'd2 && by);
    io = (sp == 2'd2);
    cfg_wait_en = wen;
    case (sp)
      2'd1: cfg_attr_len = LW'(lraw);
      2'd2: cfg_io_len = LW'(lraw);
      default: cfg_common_len = LW'(lraw);
    endcase
    if (wen) L = (lraw < 5) ? 5 : lraw;
    else     L = (lraw == 0) ? 1 : lraw;
    if (wen && j >= 0 && (j + 2) < (L - 4)) S = r + 7;
    else S = L;
    ce2e = by;
    rege = (sp == 2'd0);
    a0e  = by & ad[0];
    exp_rd = by ? {8'h00, rd[7:0]} : rd;
    exp_wd = by ? {8'h00, wd[7:0]} : wd;
    if (refuse) begin
      q.push_back({7'b111_1111, 1'b1, 1'b1, 1'b0, 1'b0});
      n = 4;
    end else begin
      q.push_back({1'b0, ce2e, rege, 4'b1111, 1'b0, 1'b0, 1'b0, wr});
      for (int k = 0; k < S; k++)
        q.push_back({1'b0, ce2e, rege, !(!io && !wr), !(!io && wr), !(io && !wr),
                     !(io && wr), 1'b0, 1'b0, 1'b0, wr});
      q.push_back({1'b0, ce2e, rege, 4'b1111, 1'b0, 1'b0, 1'b0, wr});
      q.push_back({7'b111_1111, 1'b1, 1'b0, 1'b0, 1'b0});
      n = S + 6;
    end
    while (q.size() < n) q.push_back(IDLE_V);
    // issue request at a falling edge, accepted at the next rising edge
    req_space = sp; req_write = wr; req_byte = by; req_addr = ad; req_wdata = wd;
    card_din = ~rd;
    req_valid = 1'b1;
    @(posedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, 32'(pins()), 32'(q[i]));
      if (!refuse && i <= S + 1) begin
        check({tag, " addr"}, 32'(card_addr), 32'({ad[AW-1:1], a0e}));
        if (wr) check({tag, " dout R11"}, 32'(card_dout), 32'(exp_wd));
      end
      if (!refuse && !wr && i == S + 2)
        check({tag, " rdata R10"}, 32'(rsp_rdata), 32'(exp_rd));
      // drivers for the next interval
      if (i == 0) begin
        if (poke) begin
          req_valid = 1'b1; req_space = 2'd1; req_write = ~wr; req_addr = ~ad;
        end else begin
          req_valid = 1'b0;
        end
      end
      if (i == 1) req_valid = 1'b0;
      if (j >= 0 && i - 1 == j) card_wait_n = 1'b0;
      if (i - 1 == r) card_wait_n = 1'b1;
      if (i == S) card_din = rd;
      if (i == S + 1) card_din = rd ^ 16'h5A5A;
    end
    card_wait_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet bus in reset
    check("R1 reset", 32'(pins()), 32'(IDLE_V));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle", 32'(pins()), 32'(IDLE_V));

    run_txn("R2 common word read", 2'd0, 1'b0, 1'b0, 11'h124, 16'h0, 16'h1234, 1'b0, 6, -1, -1, 1'b0);
    run_txn("R3 attr word write", 2'd1, 1'b1, 1'b0, 11'h2A2, 16'hBEEF, 16'h0, 1'b0, 9, -1, -1, 1'b0);
    run_txn("R3 io word read", 2'd2, 1'b0, 1'b0, 11'h031, 16'h0, 16'hC0DE, 1'b0, 7, -1, -1, 1'b0);
    run_txn("R3 io word write", 2'd2, 1'b1, 1'b0, 11'h040, 16'hA55A, 16'h0, 1'b0, 3, -1, -1, 1'b0);
    run_txn("R4 byte read odd", 2'd0, 1'b0, 1'b1, 11'h0F3, 16'h0, 16'h77E1, 1'b0, 4, -1, -1, 1'b0);
    run_txn("R4 byte write even", 2'd1, 1'b1, 1'b1, 11'h1F2, 16'hFF3C, 16'h0, 1'b0, 5, -1, -1, 1'b0);
    run_txn("R5 io byte refused", 2'd2, 1'b0, 1'b1, 11'h011, 16'h0, 16'h0, 1'b0, 7, -1, -1, 1'b0);
    run_txn("R5 io byte write refused", 2'd2, 1'b1, 1'b1, 11'h010, 16'h1, 16'h0, 1'b0, 7, -1, -1, 1'b0);
    run_txn("R5 reserved space", 2'd3, 1'b0, 1'b0, 11'h000, 16'h0, 16'h0, 1'b0, 7, -1, -1, 1'b0);
    run_txn("R6 wait ignored", 2'd0, 1'b0, 1'b0, 11'h200, 16'h0, 16'h4242, 1'b0, 12, 0, 3, 1'b0);
    run_txn("R7 wait stretch", 2'd2, 1'b0, 1'b0, 11'h050, 16'h0, 16'h9182, 1'b1, 12, 1, 8, 1'b0);
    run_txn("R7 short stretch write", 2'd1, 1'b1, 1'b0, 11'h066, 16'h6161, 16'h0, 1'b1, 20, 0, 2, 1'b0);
    run_txn("R8 last window cycle", 2'd0, 1'b0, 1'b0, 11'h300, 16'h0, 16'h3C3C, 1'b1, 12, 5, 6, 1'b0);
    run_txn("R8 past window", 2'd0, 1'b0, 1'b0, 11'h302, 16'h0, 16'hC3C3, 1'b1, 12, 6, 7, 1'b0);
    run_txn("R9 floor five", 2'd1, 1'b0, 1'b0, 11'h008, 16'h0, 16'h0BAD, 1'b1, 2, -1, -1, 1'b0);
    run_txn("R9 zero is one", 2'd0, 1'b0, 1'b0, 11'h00A, 16'h0, 16'hF00D, 1'b0, 0, -1, -1, 1'b0);
    run_txn("R10 byte read stretched", 2'd0, 1'b0, 1'b1, 11'h111, 16'h0, 16'hABCD, 1'b1, 10, 2, 5, 1'b0);
    run_txn("R12 request while busy", 2'd0, 1'b0, 1'b0, 11'h222, 16'h0, 16'h5555, 1'b0, 6, -1, -1, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

endmodule